// File: doc/BRIEF.md
# Watchdog Timer with Write-Locked Mode Register

This block is a retriggerable one-shot watchdog. After reset it stays idle until software issues its first kick. That kick arms the timer. Each later kick restarts the count from zero. If the count reaches its terminal value before the next kick, the block raises a reset request for a fixed number of system clocks. It then drops back to the idle state and waits for a new kick.

The timer runs from one of two timer clocks, an internal RC oscillator or an external crystal input. A bit in the mode register picks the clock. Two further mode bits pick one of four terminal counts. The mode register can be written only during the first 60 system clocks after reset. After that a lock status goes high and every later write is dropped until the next reset. Kicks cross into the timer domain, and expiries cross back into the system domain, through toggle synchronisers.

Top module: `wdt_locked`

## Requirements
- R1: While reset is applied and right after it is released, `wdt_rst_o` is 0, `mode_o` is 0x00 and `lock_o` is 0.
- R2: Until the first kick after reset, the watchdog never raises `wdt_rst_o`, however long it runs.
- R3: The first kick arms the timer. If no further kick arrives, `wdt_rst_o` rises once the terminal count has elapsed in timer clocks, give or take a few clocks of synchroniser latency.
- R4: Each kick while the timer is armed restarts the count from zero. Kicks spaced closer than the terminal count keep `wdt_rst_o` low.
- R5: `mode_o[1:0]` selects the terminal count as 2^(B + 2*sel) timer clocks, where B is the parameter `TC_BASE_LOG2`. With B = 10 this gives 2^10, 2^12, 2^14 and 2^16.
- R6: `mode_o[4]` selects the timer clock: 0 selects `rc_clk_i` and 1 selects `xtal_clk_i`.
- R7: A write with `mode_we_i` high is stored in `mode_o`, all 8 bits, at the clock edge, provided that edge is one of the first 60 system clock edges after reset release.
- R8: `lock_o` rises at the 60th system clock edge after reset release and stays high until reset. While `lock_o` is high, writes leave `mode_o` unchanged.
- R9: A reset request lasts exactly 16 system clocks. Afterwards the watchdog is disarmed, and no further request occurs until it is kicked again.
- R10: A timeout leaves `mode_o` and `lock_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rc_clk_i | input | 1 | Internal RC timer clock |
| xtal_clk_i | input | 1 | External crystal timer clock |
| kick_i | input | 1 | One-cycle watchdog refresh strobe (system domain) |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 8 | Mode register write data |
| wdt_rst_o | output | 1 | Reset request pulse |
| mode_o | output | 8 | Mode register contents |
| lock_o | output | 1 | Mode register write-protect status |

## Verification
Four properties are checked on every system clock:
- the lock status never falls once it has risen;
- a write during the lock is dropped;
- a write while unlocked is stored;
- no reset request occurs before the first kick.

In the timer domain, a property keeps the count within its selected limit. The bench scenarios are the only place where the timing is checked end to end. They measure the timeout delay for different terminal counts and timer clocks, show that regular kicks hold off the reset, count the pulse width, and confirm that the watchdog goes quiet after a timeout.

// File: rtl/wdt_locked.sv
module wdt_locked #(
  parameter int TC_BASE_LOG2 = 10,
  parameter int LOCK_CYCLES  = 60,
  parameter int PULSE_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rc_clk_i,
  input  logic       xtal_clk_i,
  input  logic       kick_i,
  input  logic       mode_we_i,
  input  logic [7:0] mode_wdata_i,
  output logic       wdt_rst_o,
  output logic [7:0] mode_o,
  output logic       lock_o
);
  localparam int TW = TC_BASE_LOG2 + 7;
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [7:0]    mode_q;
  logic [LW-1:0] lock_cnt;
  logic          kick_tgl, kicked_seen;
  logic [2:0]    exp_sync;
  logic [PW-1:0] pulse_cnt;

  logic          tclk;
  logic [2:0]    kick_sync;
  logic          t_armed, exp_tgl;
  logic [TW-1:0] t_cnt, tc_last;

  assign tclk      = mode_q[4] ? xtal_clk_i : rc_clk_i;
  assign tc_last   = (TW'(1) << (TC_BASE_LOG2 + 2 * int'(mode_q[1:0]))) - TW'(1);
  assign lock_o    = (lock_cnt == LW'(LOCK_CYCLES));
  assign mode_o    = mode_q;
  assign wdt_rst_o = (pulse_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_cnt    <= '0;
      mode_q      <= '0;
      kick_tgl    <= 1'b0;
      kicked_seen <= 1'b0;
      exp_sync    <= '0;
      pulse_cnt   <= '0;
    end else begin
      if (!lock_o) lock_cnt <= lock_cnt + LW'(1);
      if (mode_we_i && !lock_o) mode_q <= mode_wdata_i;
      if (kick_i) begin
        kick_tgl    <= ~kick_tgl;
        kicked_seen <= 1'b1;
      end
      exp_sync <= {exp_sync[1:0], exp_tgl};
      if (exp_sync[2] ^ exp_sync[1]) pulse_cnt <= PW'(PULSE_CYCLES);
      else if (pulse_cnt != '0)      pulse_cnt <= pulse_cnt - PW'(1);
    end
  end

  always_ff @(posedge tclk or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_sync <= '0;
      t_armed   <= 1'b0;
      t_cnt     <= '0;
      exp_tgl   <= 1'b0;
    end else begin
      kick_sync <= {kick_sync[1:0], kick_tgl};
      if (kick_sync[2] ^ kick_sync[1]) begin
        t_armed <= 1'b1;
        t_cnt   <= '0;
      end else if (t_armed) begin
        if (t_cnt == tc_last) begin
          t_armed <= 1'b0;
          t_cnt   <= '0;
          exp_tgl <= ~exp_tgl;
        end else begin
          t_cnt <= t_cnt + TW'(1);
        end
      end
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o); // R8
  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && mode_we_i) |=> $stable(mode_o)); // R8
  AST_OPEN_WRITE_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_o && mode_we_i) |=> (mode_o == $past(mode_wdata_i))); // R7
  AST_NO_RST_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kicked_seen |-> !wdt_rst_o); // R2
  AST_TCNT_BOUND: assert property (@(posedge tclk) disable iff (!rst_ni)
    t_cnt <= tc_last); // R5
endmodule

// File: tb/wdt_locked_tb_top.sv
`timescale 1ns/1ps
module wdt_locked_tb_top;
  localparam int  B    = 4;
  localparam real TRC  = 40.0;
  localparam real TXT  = 100.0;

  logic clk = 0, rc = 0, xt = 0;
  logic rst_n = 0, kick = 0, we = 0;
  logic [7:0] wdata = 0;
  logic wdt_rst, lock;
  logic [7:0] mode;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  always #(TRC/2) rc = ~rc;
  always #(TXT/2) xt = ~xt;

  wdt_locked #(.TC_BASE_LOG2(B)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rc_clk_i(rc), .xtal_clk_i(xt),
    .kick_i(kick), .mode_we_i(we), .mode_wdata_i(wdata),
    .wdt_rst_o(wdt_rst), .mode_o(mode), .lock_o(lock));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; kick = 0; we = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic write_mode(input logic [7:0] v);
    wdata = v; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic do_kick();
    kick = 1;
    @(negedge clk);
    kick = 0;
  endtask

  task automatic t_reset_state();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(wdt_rst == 0 && mode == 0 && lock == 0, "R1 in reset", {wdt_rst, mode, lock}, 0);
    rst_n = 1;
    @(negedge clk);
    check(wdt_rst == 0 && mode == 0 && lock == 0, "R1 after release", {wdt_rst, mode, lock}, 0);
  endtask

  task automatic t_lock_window();
    do_reset();
    repeat (59) @(negedge clk);
    check(lock == 0, "R8 lock low after 59 edges", lock, 0);
    write_mode(8'h5A);
    check(mode == 8'h5A, "R7 write on edge 60", mode, 8'h5A);
    check(lock == 1, "R8 lock high after edge 60", lock, 1);
    write_mode(8'hA5);
    check(mode == 8'h5A, "R8 write ignored when locked", mode, 8'h5A);
    repeat (200) @(negedge clk);
    check(lock == 1, "R8 lock stays high", lock, 1);
  endtask

  task automatic t_unarmed();
    int seen = 0;
    do_reset();
    write_mode(8'h00);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    check(seen == 0, "R2 no reset before first kick", seen, 0);
  endtask

  task automatic t_timeout(input logic [7:0] m, input real tper, input string tag);
    longint tc = longint'(1) << (B + 2 * m[1:0]);
    real t0, dt, lo, hi;
    int pulse = 0, extra = 0, guard = 0;
    do_reset();
    write_mode(m);
    wait (lock == 1);
    @(negedge clk);
    t0 = $realtime;
    do_kick();
    while (!wdt_rst && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    dt = $realtime - t0;
    lo = (tc - 1) * tper;
    hi = (tc + 5) * tper + 50.0;
    check(wdt_rst && dt >= lo && dt <= hi, {tag, " timeout delay ns"}, longint'(dt), longint'(tc * tper));
    while (wdt_rst && pulse < 100) begin
      pulse++;
      @(negedge clk);
    end
    check(pulse == 16, "R9 pulse length", pulse, 16);
    check(mode == m && lock == 1, "R10 mode/lock kept", {mode, lock}, {m, 1'b1});
    for (int i = 0; i < int'((3 * tc * tper) / 5.0); i++) begin
      @(negedge clk);
      if (wdt_rst) extra++;
    end
    check(extra == 0, "R9 disarmed after timeout", extra, 0);
  endtask

  task automatic t_refresh();
    int seen = 0, guard = 0;
    do_reset();
    write_mode(8'h00);
    do_kick();
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (wdt_rst) seen++;
      end
      do_kick();
    end
    check(seen == 0, "R4 periodic kicks hold off reset", seen, 0);
    while (!wdt_rst && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(wdt_rst == 1, "R4 reset once kicks stop", wdt_rst, 1);
  endtask

  initial begin
    #3ms;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_lock_window();
    t_unarmed();
    t_timeout(8'h00, TRC, "R3 R5 rc sel0");
    t_timeout(8'h01, TRC, "R5 rc sel1");
    t_timeout(8'h02, TRC, "R5 rc sel2");
    t_timeout(8'h10, TXT, "R6 xtal sel0");
    t_timeout(8'h11, TXT, "R6 xtal sel1");
    t_refresh();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule